// File: doc/BRIEF.md
# Microinstruction Next-Address Sequencer

This block picks the address of the next word to read from a vertical-format control store of 2048 words of 22 bits each. It holds the 11-bit control address in a register. On every clock edge it loads that register from one of five places: the current address plus one, a start address worked out from the machine opcode, the target carried in the microinstruction, a single saved return address, or a fixed interrupt-service address.

The store sits outside the block. It reads the word at `ctrlAddr` and feeds back only the sequencing fields of that word. Those fields are an interrupt-test bit, a 3-bit sequencing operation, a condition select and a target address. The block also takes the opcode of the machine instruction, a pending-interrupt line and a small flag vector. Decoding the datapath control bits of the word is left to other logic.

Only one operation is coded per word, so priority matters when the interrupt-test bit is set and an interrupt is pending. That case beats the coded operation, whatever it is. After that the order is return, then call or branch, then opcode map, then increment.

Top module: `micro_seq`

## Requirements
- R1: While `rstN` is low, `ctrlAddr` is 0 and the saved return address is cleared to 0. A return executed as the first operation after reset goes to address 0.
- R2: Operation code 0, and the reserved codes 6 and 7, load `ctrlAddr + 1` on the next edge. The addition wraps, so 2047 is followed by 0.
- R3: Operation code 1 loads the opcode-mapped start address, which is 0x100 + 8 × `opcode`.
- R4: Operation code 2 is an unconditional branch and loads `branchAddr`.
- R5: Operation code 3 is a conditional branch. It loads `branchAddr` when `flags[condSel]` is 1, and `ctrlAddr + 1` when that flag is 0.
- R6: Operation code 4 is a call. It loads `branchAddr` and saves `ctrlAddr + 1` as the single return address. A second call made before a return replaces the saved address.
- R7: Operation code 5 is a return and loads the saved return address. The saved address stays unchanged, so a later return goes to the same place.
- R8: When `testIrq` and `irqPending` are both 1, the next address is 0x7F0, whatever the operation code. A call overridden in this way does not change the saved return address.
- R9: When `testIrq` is 0, `irqPending` has no effect. When `testIrq` is 1 and `irqPending` is 0, the coded operation is carried out as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| testIrq | input | 1 | Interrupt-test bit of the current microinstruction |
| irqPending | input | 1 | An interrupt is waiting to be serviced |
| seqOp | input | 3 | Sequencing operation: 0 increment, 1 map, 2 jump, 3 conditional branch, 4 call, 5 return, 6 and 7 increment |
| condSel | input | 2 | Index of the flag tested by a conditional branch |
| flags | input | 4 | Condition flags |
| branchAddr | input | 11 | Target field of the current microinstruction |
| opcode | input | 4 | Machine instruction opcode used by the map operation |
| ctrlAddr | output | 11 | Registered control-store address |

## Verification
Several rules are checked by the assertions on every cycle:
- exactly one address source is chosen;
- a pending, tested interrupt always reaches the vector and never saves a return address;
- the increment, jump and return paths land on the value that was offered one cycle earlier;
- a call stores the address that follows it.

Other behaviour only shows up across several microinstructions, so the bench's scenarios cover it:
- the map arithmetic at the ends of the opcode range;
- wrap-around at the top of the store;
- a return address that survives an interrupt detour;
- an overwrite by a second call;
- a return right after reset.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [2:0] {
    OP_NEXT  = 3'd0,
    OP_MAP   = 3'd1,
    OP_JUMP  = 3'd2,
    OP_BCOND = 3'd3,
    OP_CALL  = 3'd4,
    OP_RET   = 3'd5
  } seq_op_e;

  // one-hot source picks plus the return-save strobe
  typedef struct packed {
    logic pickInc;
    logic pickMap;
    logic pickTarget;
    logic pickRet;
    logic pickVec;
    logic saveRet;
  } seq_strobe_t;

endpackage

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int FLAG_W = 4,
  localparam int SEL_W = (FLAG_W > 1) ? $clog2(FLAG_W) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              testIrq,
  input  logic              irqPending,
  input  logic [2:0]        seqOp,
  input  logic [SEL_W-1:0]  condSel,
  input  logic [FLAG_W-1:0] flags,
  output seq_strobe_t       strobes
);

  logic irqHit;
  logic condTrue;

  assign irqHit   = testIrq & irqPending;
  assign condTrue = flags[condSel];

  always_comb begin
    strobes = '0;
    if (irqHit) begin
      strobes.pickVec = 1'b1;
    end else begin
      unique case (seqOp)
        OP_RET:   strobes.pickRet = 1'b1;
        OP_CALL: begin
          strobes.pickTarget = 1'b1;
          strobes.saveRet    = 1'b1;
        end
        OP_JUMP:  strobes.pickTarget = 1'b1;
        OP_BCOND: begin
          strobes.pickTarget = condTrue;
          strobes.pickInc    = ~condTrue;
        end
        OP_MAP:   strobes.pickMap = 1'b1;
        default:  strobes.pickInc = 1'b1;
      endcase
    end
  end

  assert_single_pick_R2: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobes.pickInc, strobes.pickMap, strobes.pickTarget,
                strobes.pickRet, strobes.pickVec}) == 1);

  assert_irq_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    (testIrq && irqPending) |-> (strobes.pickVec && !strobes.saveRet));

endmodule

// File: rtl/useq_path.sv
module useq_path
  import useq_pkg::*;
#(
  parameter int                ADDR_W     = 11,
  parameter int                OPC_W      = 4,
  parameter int                MAP_SHIFT  = 3,
  parameter logic [ADDR_W-1:0] MAP_BASE   = 11'h100,
  parameter logic [ADDR_W-1:0] IRQ_VEC    = 11'h7F0,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       strobes,
  input  logic [ADDR_W-1:0] branchAddr,
  input  logic [OPC_W-1:0]  opcode,
  output logic [ADDR_W-1:0] addrQ
);

  logic [ADDR_W-1:0] retQ;
  logic [ADDR_W-1:0] incAddr;
  logic [ADDR_W-1:0] mapAddr;
  logic [ADDR_W-1:0] nextAddr;

  assign incAddr = addrQ + ADDR_W'(1);
  assign mapAddr = MAP_BASE + (ADDR_W'(opcode) << MAP_SHIFT);

  always_comb begin
    nextAddr = incAddr;
    if (strobes.pickVec)         nextAddr = IRQ_VEC;
    else if (strobes.pickRet)    nextAddr = retQ;
    else if (strobes.pickTarget) nextAddr = branchAddr;
    else if (strobes.pickMap)    nextAddr = mapAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= RESET_ADDR;
      retQ  <= RESET_ADDR;
    end else begin
      addrQ <= nextAddr;
      if (strobes.saveRet) retQ <= incAddr;
    end
  end

  assert_call_saves_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.saveRet |=> (retQ == ADDR_W'($past(addrQ) + 1)));

  assert_ret_loads_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pickRet |=> (addrQ == $past(retQ)));

  assert_ret_kept_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.saveRet |=> $stable(retQ));

endmodule

// File: rtl/micro_seq.sv
module micro_seq
  import useq_pkg::*;
#(
  parameter int                ADDR_W     = 11,
  parameter int                OPC_W      = 4,
  parameter int                FLAG_W     = 4,
  parameter int                MAP_SHIFT  = 3,
  parameter logic [ADDR_W-1:0] MAP_BASE   = 11'h100,
  parameter logic [ADDR_W-1:0] IRQ_VEC    = 11'h7F0,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  localparam int               SEL_W      = (FLAG_W > 1) ? $clog2(FLAG_W) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              testIrq,
  input  logic              irqPending,
  input  logic [2:0]        seqOp,
  input  logic [SEL_W-1:0]  condSel,
  input  logic [FLAG_W-1:0] flags,
  input  logic [ADDR_W-1:0] branchAddr,
  input  logic [OPC_W-1:0]  opcode,
  output logic [ADDR_W-1:0] ctrlAddr
);

  seq_strobe_t strobes;

  useq_ctrl #(.FLAG_W(FLAG_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .testIrq    (testIrq),
    .irqPending (irqPending),
    .seqOp      (seqOp),
    .condSel    (condSel),
    .flags      (flags),
    .strobes    (strobes)
  );

  useq_path #(
    .ADDR_W     (ADDR_W),
    .OPC_W      (OPC_W),
    .MAP_SHIFT  (MAP_SHIFT),
    .MAP_BASE   (MAP_BASE),
    .IRQ_VEC    (IRQ_VEC),
    .RESET_ADDR (RESET_ADDR)
  ) path_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .branchAddr (branchAddr),
    .opcode     (opcode),
    .addrQ      (ctrlAddr)
  );

  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rstN)
    (seqOp == 3'd0 && !(testIrq && irqPending)) |=> (ctrlAddr == ADDR_W'($past(ctrlAddr) + 1)));

  assert_jump_target_R4: assert property (@(posedge clk) disable iff (!rstN)
    (seqOp == 3'd2 && !(testIrq && irqPending)) |=> (ctrlAddr == $past(branchAddr)));

  assert_vector_R8: assert property (@(posedge clk) disable iff (!rstN)
    (testIrq && irqPending) |=> (ctrlAddr == IRQ_VEC));

endmodule

// File: tb/micro_seq_tb_top.sv
module micro_seq_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        testIrq = 1'b0;
  logic        irqPending = 1'b0;
  logic [2:0]  seqOp = 3'd0;
  logic [1:0]  condSel = 2'd0;
  logic [3:0]  flags = 4'd0;
  logic [10:0] branchAddr = 11'd0;
  logic [3:0]  opcode = 4'd0;
  logic [10:0] ctrlAddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  micro_seq dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .testIrq    (testIrq),
    .irqPending (irqPending),
    .seqOp      (seqOp),
    .condSel    (condSel),
    .flags      (flags),
    .branchAddr (branchAddr),
    .opcode     (opcode),
    .ctrlAddr   (ctrlAddr)
  );

  typedef struct packed {
    logic        tst;
    logic        irq;
    logic [2:0]  op;
    logic [1:0]  sel;
    logic [3:0]  flg;
    logic [10:0] tgt;
    logic [3:0]  opc;
    logic [10:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,3'd0,2'd0,4'h0,11'h000,4'd0,11'h001,4'd2},  // R2
    '{1'b0,1'b0,3'd0,2'd0,4'h0,11'h000,4'd0,11'h002,4'd2},  // R2
    '{1'b0,1'b0,3'd2,2'd0,4'h0,11'h050,4'd0,11'h050,4'd4},  // R4
    '{1'b0,1'b0,3'd3,2'd2,4'h4,11'h200,4'd0,11'h200,4'd5},  // R5 taken
    '{1'b0,1'b0,3'd3,2'd1,4'h4,11'h300,4'd0,11'h201,4'd5},  // R5 not taken
    '{1'b0,1'b0,3'd4,2'd0,4'h0,11'h400,4'd0,11'h400,4'd6},  // R6 call
    '{1'b0,1'b0,3'd0,2'd0,4'h0,11'h000,4'd0,11'h401,4'd2},
    '{1'b0,1'b0,3'd5,2'd0,4'h0,11'h000,4'd0,11'h202,4'd7},  // R7
    '{1'b0,1'b0,3'd1,2'd0,4'h0,11'h000,4'd5,11'h128,4'd3},  // R3
    '{1'b1,1'b0,3'd0,2'd0,4'h0,11'h000,4'd0,11'h129,4'd9},  // R9 test, none pending
    '{1'b1,1'b1,3'd0,2'd0,4'h0,11'h000,4'd0,11'h7F0,4'd8},  // R8
    '{1'b0,1'b1,3'd0,2'd0,4'h0,11'h000,4'd0,11'h7F1,4'd9},  // R9 untested irq ignored
    '{1'b0,1'b0,3'd4,2'd0,4'h0,11'h010,4'd0,11'h010,4'd6},
    '{1'b1,1'b1,3'd5,2'd0,4'h0,11'h000,4'd0,11'h7F0,4'd8},  // R8 beats return
    '{1'b0,1'b0,3'd5,2'd0,4'h0,11'h000,4'd0,11'h7F2,4'd7},
    '{1'b1,1'b1,3'd4,2'd0,4'h0,11'h020,4'd0,11'h7F0,4'd8},  // R8 beats call
    '{1'b0,1'b0,3'd5,2'd0,4'h0,11'h000,4'd0,11'h7F2,4'd8},  // R8 return kept
    '{1'b0,1'b0,3'd4,2'd0,4'h0,11'h030,4'd0,11'h030,4'd6},
    '{1'b0,1'b0,3'd4,2'd0,4'h0,11'h040,4'd0,11'h040,4'd6},  // R6 overwrite
    '{1'b0,1'b0,3'd5,2'd0,4'h0,11'h000,4'd0,11'h031,4'd6},
    '{1'b0,1'b0,3'd1,2'd0,4'h0,11'h000,4'd15,11'h178,4'd3}, // R3 top opcode
    '{1'b0,1'b0,3'd1,2'd0,4'h0,11'h000,4'd0,11'h100,4'd3},  // R3 opcode 0
    '{1'b0,1'b0,3'd7,2'd0,4'h0,11'h000,4'd0,11'h101,4'd2},  // R2 reserved code
    '{1'b0,1'b0,3'd2,2'd0,4'h0,11'h7FF,4'd0,11'h7FF,4'd4},
    '{1'b0,1'b0,3'd0,2'd0,4'h0,11'h000,4'd0,11'h000,4'd2},  // R2 wrap
    '{1'b1,1'b1,3'd1,2'd0,4'h0,11'h000,4'd3,11'h7F0,4'd8},  // R8 beats map
    '{1'b0,1'b0,3'd3,2'd3,4'h8,11'h555,4'd0,11'h555,4'd5}
  };

  task automatic check(input logic [10:0] exp, input int req, input string what);
    checks++;
    if (ctrlAddr !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, ctrlAddr, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    testIrq    = v.tst;
    irqPending = v.irq;
    seqOp      = v.op;
    condSel    = v.sel;
    flags      = v.flg;
    branchAddr = v.tgt;
    opcode     = v.opc;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check(11'h000, 1, "reset address");  // R1
    @(negedge clk) rstN = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(posedge clk);
      #1 check(VECS[i].exp, int'(VECS[i].req), $sformatf("vector %0d", i));
      @(negedge clk);
    end
    // R1: mid-run reset clears address and return register
    rstN = 1'b0;
    drive('{1'b0,1'b0,3'd0,2'd0,4'h0,11'h000,4'd0,11'h000,4'd1});
    @(posedge clk);
    #1 check(11'h000, 1, "reset mid-run");
    @(negedge clk) rstN = 1'b1;
    seqOp = 3'd5;
    @(posedge clk);
    #1 check(11'h000, 1, "return after reset");
    @(negedge clk) seqOp = 3'd6;
    @(posedge clk);
    #1 check(11'h001, 2, "reserved code 6");
    @(negedge clk);
    finish_run();
  end

endmodule